// File: doc/BRIEF.md
# Multimodulus Selectable Prescaler

This block divides a fast input clock by one of sixteen ratios. Its front stage is a dual-modulus core that counts either N or N+1 input cycles, and a fixed chain of sixteen core periods follows it. A two-bit core selector fixes N at 2, 4, 8 or 16. A band input moves the ratio pair from 16N / 16N+1 up to 16N+15 / 16N+16, and a modulus input picks the lower or the upper ratio of that pair. The band input only inverts the core's modulus control, so both pairs come from the same counters.

The model is cycle-accurate and runs entirely on the input clock. Each output period drives three outputs. A boundary strobe is high on the last input cycle of the period. A one-cycle pulse follows it on the first cycle of the next period. A square-like wave is high during the second half of the chain. The three controls are sampled only when a period ends, so no period ever mixes two ratios.

Top module: `multimod_prescaler`

## Requirements
- R1: A synchronous active-high reset clears both counters and all outputs. The controls present on the last reset cycle set the first period. The first boundary strobe comes on input cycle R-1 after reset is released, where R is that period's ratio.
- R2: The core selector sets N as follows: 2'b10 gives N=2, 2'b11 gives N=4, 2'b00 gives N=8 and 2'b01 gives N=16.
- R3: With band=0 and modulus=1, every core period lasts N cycles, so the ratio is 16N (32, 64, 128, 256).
- R4: With band=0 and modulus=0, the last of the 16 core periods lasts N+1 cycles, so the ratio is 16N+1 (33, 65, 129, 257).
- R5: With band=1 and modulus=1, every core period lasts N+1 cycles, so the ratio is 16N+16 (48, 80, 144, 272).
- R6: With band=1 and modulus=0, the last core period lasts N cycles, so the ratio is 16N+15 (47, 79, 143, 271).
- R7: Only the last core period of a period can have the odd length. `squareOut` is high from input cycle 8*L up to the end of the period, where L is N for band=0 and N+1 for band=1.
- R8: A change to the selector, band or modulus during a period has no effect on that period. It takes effect from the next period.
- R9: `pulseOut` is high for exactly one cycle, on the cycle after each boundary strobe, and is low at every other time.
- R10: `periodEnd` is high for exactly one input cycle in each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| coreSel | input | 2 | Core size selector (see R2) |
| bandSel | input | 1 | 0: 16N/16N+1 pair, 1: 16N+15/16N+16 pair |
| modSel | input | 1 | 1: upper-or-flat ratio of the pair as in R3/R5, 0: as in R4/R6 |
| pulseOut | output | 1 | One-cycle pulse at the start of each period |
| squareOut | output | 1 | High during the second half of the chain |
| periodEnd | output | 1 | High on the last input cycle of each period |

## Verification
The assertions assume that the controls are synchronous to the clock and take a defined value on every cycle, including the last reset cycle. This matters because the configuration register loads from them during reset. They also assume the shortest period is 32 cycles, so that two boundary strobes are never adjacent. The stimulus changes the controls only on falling edges and holds them through each reset. It sweeps all sixteen combinations and deliberately changes them partway through periods. This tests whether the block sampled them at the boundary and not while the period was running.

// File: rtl/presc_pkg.sv
package presc_pkg;

  typedef struct packed {
    logic [1:0] coreSel;
    logic       bandSel;
    logic       modSel;
  } cfg_t;

  typedef struct packed {
    logic coreWrap;
    logic periodWrap;
  } strobes_t;

  // core size N for each selector code
  function automatic int unsigned coreBase(input logic [1:0] sel);
    case (sel)
      2'b10:   return 2;
      2'b11:   return 4;
      2'b00:   return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl
  import presc_pkg::*;
#(
  parameter int CORE_W    = 5,
  parameter int CHAIN_W   = 4,
  parameter int CHAIN_LEN = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  cfg_t               cfgIn,
  input  logic [CORE_W-1:0]  coreCnt,
  input  logic [CHAIN_W-1:0] chainCnt,
  output strobes_t           strb
);

  localparam logic [CHAIN_W-1:0] CHAIN_TOP = CHAIN_W'(CHAIN_LEN - 1);

  cfg_t              cfgReg;
  logic              chainLast;
  logic              modCtl;
  logic              useLong;
  logic [CORE_W-1:0] baseN;
  logic [CORE_W-1:0] coreLen;

  always_comb begin
    chainLast = (chainCnt == CHAIN_TOP);
    // modulus control: held high except in the last core period when modSel=0
    modCtl  = cfgReg.modSel | ~chainLast;
    // band select inverts the sense of the modulus control
    useLong = ~(modCtl ^ cfgReg.bandSel);
    baseN   = CORE_W'(coreBase(cfgReg.coreSel));
    coreLen = baseN + CORE_W'(useLong);
    strb.coreWrap   = (coreCnt == coreLen - CORE_W'(1));
    strb.periodWrap = strb.coreWrap & chainLast;
  end

  always_ff @(posedge clk) begin
    if (rst)                  cfgReg <= cfgIn;
    else if (strb.periodWrap) cfgReg <= cfgIn;
  end

  // R8: configuration moves only across a period boundary
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strb.periodWrap |=> $stable(cfgReg));

  // R7: every core period before the last has the band's regular length
  p_regular_len_r7: assert property (@(posedge clk) disable iff (rst)
    (chainCnt != CHAIN_TOP) |-> (coreLen == baseN + CORE_W'(cfgReg.bandSel)));

endmodule

// File: rtl/presc_dp.sv
module presc_dp
  import presc_pkg::*;
#(
  parameter int CORE_W    = 5,
  parameter int CHAIN_W   = 4,
  parameter int CHAIN_LEN = 16,
  parameter int CORE_MAX  = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strb,
  output logic [CORE_W-1:0]  coreCnt,
  output logic [CHAIN_W-1:0] chainCnt,
  output logic               pulseReg,
  output logic               squareOut
);

  localparam logic [CHAIN_W-1:0] CHAIN_TOP = CHAIN_W'(CHAIN_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      coreCnt  <= '0;
      chainCnt <= '0;
      pulseReg <= 1'b0;
    end else begin
      pulseReg <= strb.periodWrap;
      if (strb.coreWrap) begin
        coreCnt  <= '0;
        chainCnt <= (chainCnt == CHAIN_TOP) ? '0 : chainCnt + CHAIN_W'(1);
      end else begin
        coreCnt <= coreCnt + CORE_W'(1);
      end
    end
  end

  assign squareOut = chainCnt[CHAIN_W-1];

  // R7: the chain advances only when a core period completes
  p_chain_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.coreWrap |=> $stable(chainCnt));

  // R2: core count never runs past the largest core length
  p_core_limit_r2: assert property (@(posedge clk) disable iff (rst)
    coreCnt < CORE_W'(CORE_MAX));

  // R10: a period boundary always closes the chain
  p_wrap_chain_r10: assert property (@(posedge clk) disable iff (rst)
    strb.periodWrap |=> (chainCnt == '0 && coreCnt == '0));

endmodule

// File: rtl/multimod_prescaler.sv
module multimod_prescaler
  import presc_pkg::*;
#(
  parameter int CHAIN_LEN = 16,
  parameter int CORE_MAX  = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] coreSel,
  input  logic       bandSel,
  input  logic       modSel,
  output logic       pulseOut,
  output logic       squareOut,
  output logic       periodEnd
);

  localparam int CORE_W  = $clog2(CORE_MAX);
  localparam int CHAIN_W = $clog2(CHAIN_LEN);

  cfg_t               cfgIn;
  strobes_t           strb;
  logic [CORE_W-1:0]  coreCnt;
  logic [CHAIN_W-1:0] chainCnt;

  assign cfgIn = '{coreSel: coreSel, bandSel: bandSel, modSel: modSel};

  presc_ctrl #(.CORE_W(CORE_W), .CHAIN_W(CHAIN_W), .CHAIN_LEN(CHAIN_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .cfgIn(cfgIn),
    .coreCnt(coreCnt), .chainCnt(chainCnt), .strb(strb)
  );

  presc_dp #(.CORE_W(CORE_W), .CHAIN_W(CHAIN_W), .CHAIN_LEN(CHAIN_LEN),
             .CORE_MAX(CORE_MAX)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .coreCnt(coreCnt), .chainCnt(chainCnt),
    .pulseReg(pulseOut), .squareOut(squareOut)
  );

  assign periodEnd = strb.periodWrap;

  // R10: boundary strobes never fall on adjacent cycles
  p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    periodEnd |=> !periodEnd);

  // R9: the output pulse trails each boundary strobe by one cycle
  p_pulse_follow_r9: assert property (@(posedge clk) disable iff (rst)
    periodEnd |=> pulseOut);

endmodule

// File: tb/sim_multimod_prescaler.sv
module sim_multimod_prescaler;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coreSel = 2'b10;
  logic       bandSel = 1'b0;
  logic       modSel  = 1'b1;
  logic       pulseOut, squareOut, periodEnd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  int pos = 0, curRatio = 32, curReg = 2, wraps = 0;
  bit curBand = 0, curMod = 1, expPulse = 0;
  bit afterReset = 1, midChange = 0;

  always #2 clk = ~clk;  // 250 MHz

  multimod_prescaler u0 (
    .clk(clk), .rst(rst), .coreSel(coreSel), .bandSel(bandSel),
    .modSel(modSel), .pulseOut(pulseOut), .squareOut(squareOut),
    .periodEnd(periodEnd)
  );

  function automatic int baseOf(input logic [1:0] cs);
    return (cs == 2'b10) ? 2 : (cs == 2'b11) ? 4 : (cs == 2'b00) ? 8 : 16;
  endfunction

  function automatic int ratioOf(input logic [1:0] cs, input bit b, input bit m);
    int n = baseOf(cs);
    if (!b) return m ? 16*n : 16*n + 1;
    return m ? 16*(n+1) : 16*(n+1) - 1;
  endfunction

  function automatic string ratioTag();
    if (afterReset) return "R1";
    if (midChange)  return "R8";
    if (!curBand)   return curMod ? "R2 R3" : "R2 R4";
    return curMod ? "R2 R5" : "R2 R6";
  endfunction

  task automatic loadCfg();
    curRatio = ratioOf(coreSel, bandSel, modSel);
    curReg   = bandSel ? baseOf(coreSel) + 1 : baseOf(coreSel);
    curBand  = bandSel;
    curMod   = modSel;
  endtask

  // behavioural model: cycle position within the current period
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      pos = 0; expPulse = 0; afterReset = 1; midChange = 0;
      loadCfg();
    end else if (pos == curRatio - 1) begin
      pos = 0; expPulse = 1; wraps++;
      afterReset = 0; midChange = 0;
      loadCfg();
    end else begin
      pos++; expPulse = 0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // compared on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic expEnd;
      expEnd = (pos == curRatio - 1);
      if (periodEnd === 1'b1 && !expEnd)
        check("R10", periodEnd, expEnd, "periodEnd extra strobe");
      else
        check(ratioTag(), periodEnd, expEnd, "periodEnd");
      check("R9", pulseOut, expPulse, "pulseOut");
      check("R7", squareOut, (pos >= 8*curReg), "squareOut");
    end
  end

  task automatic waitWraps(input int k);
    int target = wraps + k;
    while (wraps < target) @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] cs, input bit b, input bit m);
    @(negedge clk);
    rst = 1; coreSel = cs; bandSel = b; modSel = m;
    repeat (2) @(negedge clk);
    // R1: outputs cleared while reset is held
    check("R1", periodEnd, 1'b0, "periodEnd in reset");
    check("R1", pulseOut,  1'b0, "pulseOut in reset");
    check("R1", squareOut, 1'b0, "squareOut in reset");
    rst = 0;
  endtask

  initial begin
    doReset(2'b10, 1'b0, 1'b1);
    waitWraps(2);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      coreSel = c[3:2]; bandSel = c[1]; modSel = c[0];
      waitWraps(3);
    end
    // R8: change controls in the middle of a period
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      coreSel = 2'(c); bandSel = c[0]; modSel = ~c[1];
      waitWraps(1);
      repeat (7 + 3*c) @(negedge clk);
      midChange = 1;
      coreSel = 2'(c + 1); bandSel = ~bandSel; modSel = ~modSel;
      waitWraps(2);
    end
    // R1: reset in mid-period, then a full first period
    repeat (11) @(negedge clk);
    doReset(2'b01, 1'b1, 1'b0);
    waitWraps(2);
    doReset(2'b11, 1'b0, 1'b0);
    waitWraps(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule